// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a CPU byte bus and a flash array and lets a program or erase operation start only after a fixed three-step ritual. First, software writes to any address in the array window. The block captures that address and byte instead of storing it. Second, software writes a command code into the command register. Third, software writes a 1 to the buffer-empty bit of the status register. If all three arrive in that order and the code is legal, the block issues a one-cycle start to the array with the command, the address and the data. It then waits for the array's done pulse and raises the complete flag.

Any step out of order, an illegal code, or a 0 written to the buffer-empty bit while a sequence is pending is treated as an access error. The error sends the sequencer back to idle and blocks every new command until software clears it. A divider register must also be written once after reset before any command is taken. Its value sets the tick rate of the array stand-in, which counts a fixed number of divided ticks: a shorter count for program or blank check, a longer one for erase.

Register map: divider at 0x0010, status at 0x0011, command at 0x0012. The array window is every address at or above 0x8000. Status bits are: bit 7 buffer empty, bit 6 command complete, bit 4 access error, bit 0 divider loaded. All other status bits read 0.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0xC0 (buffer empty 1, complete 1, error 0, divider loaded 0) and op_start is low.
- R2: The sequence array write, then legal command write, then status write with bit 7 = 1 produces exactly one op_start pulse, one cycle long. It carries the command code, address and data. Status bit 7 reads 0 from the array write until the operation completes.
- R3: Legal codes are 0x05 blank check, 0x20 byte program, 0x25 burst program, 0x40 page erase and 0x41 mass erase. Writing any other code after an array write sets the error bit, returns to idle and starts nothing.
- R4: Writing status with bit 7 = 0 after the array write and before the launch aborts the sequence: error bit set, idle, no start.
- R5: A command write with no pending array write, a second array write before launch, or a launch write with no command written each set the error bit, return to idle and start nothing.
- R6: While the error bit is 1, array writes are not captured (bit 7 stays 1) and no command can start. Writing status with bit 4 = 1 clears the error bit, after which a full sequence launches again.
- R7: Until the divider register (0x0010, read back as written) has been written after reset, an array write sets the error bit and is not captured.
- R8: Status bit 6 goes low at launch and returns high when the operation finishes. With divider value d, the first status poll that shows bit 6 high comes 3 + N*(d+1) cycles after the launch edge. N is ERASE_TICKS for 0x40/0x41 and PROG_TICKS otherwise.
- R9: For page erase (0x40), op_addr has bits [8:0] forced to zero.
- R10: For 0x05, 0x40 and 0x41, op_data is 0x00. For 0x05 and 0x41, op_addr equals the captured address unchanged.
- R11: A status write that both aborts (bit 7 = 0) and clears errors (bit 4 = 1) leaves the error bit set. A write with bit 7 = 1 and bit 4 = 1 on a ready sequence launches it and leaves the error bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | CPU byte address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| op_start | output | 1 | One-cycle start pulse to the array |
| op_cmd | output | 8 | Command code issued with the start |
| op_addr | output | AW | Array address issued, page-masked for page erase |
| op_data | output | 8 | Data byte issued, zero for erase and blank check |

## Verification
The one case where two status functions land in the same write is clearing the error bit and setting it. A single status write can request the clear through bit 4 while its bit 7 value either aborts or launches the pending sequence. The bench provokes both mixes on a sequence waiting for launch. An abort-with-clear must read back with the error bit still set and no start pulse. A launch-with-clear must produce a start and a clean status after completion. A third collision, a stray array write while the array is busy, is left to the assertions on start and completion.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_CMD  = 2'd2,
    SQ_BUSY = 2'd3
  } seq_state_t;

  localparam logic [BYTE_W-1:0] OP_BLANK = 8'h05;
  localparam logic [BYTE_W-1:0] OP_BYTE  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_BURST = 8'h25;
  localparam logic [BYTE_W-1:0] OP_PAGE  = 8'h40;
  localparam logic [BYTE_W-1:0] OP_MASS  = 8'h41;

  localparam int ST_EMPTY = 7;
  localparam int ST_CMPL  = 6;
  localparam int ST_ERR   = 4;
  localparam int ST_DIVOK = 0;

  function automatic logic code_valid(input logic [BYTE_W-1:0] c);
    return (c == OP_BLANK) || (c == OP_BYTE) || (c == OP_BURST) ||
           (c == OP_PAGE)  || (c == OP_MASS);
  endfunction

  function automatic logic code_is_erase(input logic [BYTE_W-1:0] c);
    return (c == OP_PAGE) || (c == OP_MASS);
  endfunction

  function automatic logic code_no_data(input logic [BYTE_W-1:0] c);
    return (c == OP_BLANK) || (c == OP_PAGE) || (c == OP_MASS);
  endfunction

endpackage

// File: rtl/fcc_prescaler.sv
module fcc_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] pre;

  assign tick = run && (pre == div);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre <= '0;
    end else if (run) begin
      if (pre == div) pre <= '0;
      else            pre <= pre + 1'b1;
    end
  end

endmodule

// File: rtl/fcc_array_timer.sv
module fcc_array_timer #(
  parameter int DIV_W       = 8,
  parameter int PROG_TICKS  = 4,
  parameter int ERASE_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             erase,
  input  logic [DIV_W-1:0] div,
  output logic             done
);

  localparam int MAX_T = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  logic          busy;
  logic [CW-1:0] remain;
  logic          tick;

  fcc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (busy),
    .div     (div),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        remain <= erase ? CW'(ERASE_TICKS) : CW'(PROG_TICKS);
      end else if (busy && tick) begin
        if (remain == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fcc_sequencer.sv
module fcc_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_array,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              div_ok,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              done,
  output seq_state_t        state,
  output logic              acc_err,
  output logic              cmpl,
  output logic              op_start,
  output logic [BYTE_W-1:0] op_cmd,
  output logic [AW-1:0]     op_addr,
  output logic [BYTE_W-1:0] op_data
);

  localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_BITS;

  logic [AW-1:0]     lat_addr;
  logic [BYTE_W-1:0] lat_data;
  logic [BYTE_W-1:0] lat_cmd;
  logic [AW-1:0]     addr_m;
  logic [BYTE_W-1:0] data_m;

  always_comb begin
    addr_m = (lat_cmd == OP_PAGE) ? (lat_addr & PAGE_MASK) : lat_addr;
    data_m = code_no_data(lat_cmd) ? '0 : lat_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      acc_err  <= 1'b0;
      cmpl     <= 1'b1;
      op_start <= 1'b0;
      op_cmd   <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_cmd  <= '0;
    end else begin
      op_start <= 1'b0;
      if (state == SQ_BUSY && done) begin
        state <= SQ_IDLE;
        cmpl  <= 1'b1;
      end
      // clear first; any error raised below in the same cycle overrides it
      if (wr_stat && bus_wdata[ST_ERR]) acc_err <= 1'b0;

      if (wr_array) begin
        case (state)
          SQ_IDLE: begin
            if (acc_err || !div_ok) begin
              acc_err <= 1'b1;
            end else begin
              lat_addr <= bus_addr;
              lat_data <= bus_wdata;
              state    <= SQ_ADDR;
            end
          end
          SQ_ADDR, SQ_CMD: begin
            acc_err <= 1'b1;
            state   <= SQ_IDLE;
          end
          default: acc_err <= 1'b1;
        endcase
      end

      if (wr_cmd) begin
        case (state)
          SQ_ADDR: begin
            if (code_valid(bus_wdata)) begin
              lat_cmd <= bus_wdata;
              state   <= SQ_CMD;
            end else begin
              acc_err <= 1'b1;
              state   <= SQ_IDLE;
            end
          end
          SQ_CMD: begin
            acc_err <= 1'b1;
            state   <= SQ_IDLE;
          end
          default: acc_err <= 1'b1;
        endcase
      end

      if (wr_stat) begin
        case (state)
          SQ_ADDR: begin
            acc_err <= 1'b1;
            state   <= SQ_IDLE;
          end
          SQ_CMD: begin
            if (bus_wdata[ST_EMPTY]) begin
              state    <= SQ_BUSY;
              cmpl     <= 1'b0;
              op_start <= 1'b1;
              op_cmd   <= lat_cmd;
              op_addr  <= addr_m;
              op_data  <= data_m;
            end else begin
              acc_err <= 1'b1;
              state   <= SQ_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int            AW          = 16,
  parameter logic [AW-1:0] ARRAY_BASE  = 16'h8000,
  parameter logic [AW-1:0] REG_DIV     = 16'h0010,
  parameter logic [AW-1:0] REG_STAT    = 16'h0011,
  parameter logic [AW-1:0] REG_CMD     = 16'h0012,
  parameter int            PAGE_BITS   = 9,
  parameter int            PROG_TICKS  = 4,
  parameter int            ERASE_TICKS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  output logic [7:0]    bus_rdata,
  output logic          op_start,
  output logic [7:0]    op_cmd,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);

  logic              wr_array, wr_cmd, wr_stat, wr_div;
  logic [BYTE_W-1:0] div_q;
  logic              div_ok;
  logic              acc_err, cmpl, done;
  seq_state_t        seq_state;
  logic [BYTE_W-1:0] status;

  assign wr_array = bus_we && (bus_addr >= ARRAY_BASE);
  assign wr_cmd   = bus_we && (bus_addr == REG_CMD);
  assign wr_stat  = bus_we && (bus_addr == REG_STAT);
  assign wr_div   = bus_we && (bus_addr == REG_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      div_ok <= 1'b0;
    end else if (wr_div) begin
      div_q  <= bus_wdata;
      div_ok <= 1'b1;
    end
  end

  fcc_sequencer #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_array  (wr_array),
    .wr_cmd    (wr_cmd),
    .wr_stat   (wr_stat),
    .div_ok    (div_ok),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done      (done),
    .state     (seq_state),
    .acc_err   (acc_err),
    .cmpl      (cmpl),
    .op_start  (op_start),
    .op_cmd    (op_cmd),
    .op_addr   (op_addr),
    .op_data   (op_data)
  );

  fcc_array_timer #(
    .DIV_W       (BYTE_W),
    .PROG_TICKS  (PROG_TICKS),
    .ERASE_TICKS (ERASE_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (op_start),
    .erase (code_is_erase(op_cmd)),
    .div   (div_q),
    .done  (done)
  );

  always_comb begin
    status            = '0;
    status[ST_EMPTY]  = (seq_state == SQ_IDLE);
    status[ST_CMPL]   = cmpl;
    status[ST_ERR]    = acc_err;
    status[ST_DIVOK]  = div_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      if (bus_addr == REG_DIV)       bus_rdata <= div_q;
      else if (bus_addr == REG_STAT) bus_rdata <= status;
      else if (bus_addr == REG_CMD)  bus_rdata <= op_cmd;
      else                           bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          op_start,
  input logic [7:0]    op_cmd,
  input logic [AW-1:0] op_addr,
  input logic [7:0]    op_data,
  input logic          acc_err,
  input logic          div_ok,
  input logic          cmpl,
  input seq_state_t    seq_state
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) op_start |=> !op_start); // R2
  AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (rst) op_start |-> $past(seq_state) == SQ_CMD); // R2
  AST_START_NEEDS_DIV: assert property (@(posedge clk) disable iff (rst) op_start |-> div_ok); // R7
  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst) acc_err |=> !op_start); // R6
  AST_BUSY_NOT_COMPLETE: assert property (@(posedge clk) disable iff (rst) (seq_state == SQ_BUSY) |-> !cmpl); // R8
  AST_PAGE_ADDR_MASKED: assert property (@(posedge clk) disable iff (rst) (op_start && op_cmd == OP_PAGE) |-> (op_addr[PAGE_BITS-1:0] == '0)); // R9
  AST_DATA_ZERO_NODATA: assert property (@(posedge clk) disable iff (rst) (op_start && code_no_data(op_cmd)) |-> (op_data == 8'h00)); // R10
  AST_LEGAL_CODE_ONLY: assert property (@(posedge clk) disable iff (rst) op_start |-> code_valid(op_cmd)); // R3

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_start  (op_start),
  .op_cmd    (op_cmd),
  .op_addr   (op_addr),
  .op_data   (op_data),
  .acc_err   (acc_err),
  .div_ok    (div_ok),
  .cmpl      (cmpl),
  .seq_state (seq_state)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam logic [15:0] A_DIV  = 16'h0010;
  localparam logic [15:0] A_STAT = 16'h0011;
  localparam logic [15:0] A_CMD  = 16'h0012;
  localparam logic [7:0]  DIVV   = 8'd2;

  // {addr, data, cmd, expected addr, expected data, expected poll latency}
  localparam logic [63:0] VEC [0:5] = '{
    64'h8123_5A20_8123_5A0F,
    64'h9FFF_C325_9FFF_C30F,
    64'h83FF_7740_8200_001B,
    64'hA5A5_1141_A5A5_001B,
    64'hF001_EE05_F001_000F,
    64'h81FF_0140_8000_001B
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  bus_wdata = 8'h0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_rdata;
  logic        op_start;
  logic [7:0]  op_cmd;
  logic [15:0] op_addr;
  logic [7:0]  op_data;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  logic [7:0]  cap_cmd;
  logic [15:0] cap_addr;
  logic [7:0]  cap_data;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .op_start(op_start),
    .op_cmd(op_cmd), .op_addr(op_addr), .op_data(op_data)
  );

  always @(negedge clk) begin
    if (!rst && op_start) begin
      starts   <= starts + 1;
      cap_cmd  <= op_cmd;
      cap_addr <= op_addr;
      cap_data <= op_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // call right after the launch write returns; bus_addr is still the status register
  task automatic wait_done(input string tag, output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) chk({tag, " complete low while busy"}, bus_rdata, 8'h01);
    end while (!bus_rdata[6] && lat < 1000);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int lat;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 op_start low after reset", op_start, 0);
    rd(A_STAT, r); chk("R1 status after reset", r, 8'hC0);

    // R7 array write before divider is loaded
    wr(16'h8000, 8'h12);
    rd(A_STAT, r); chk("R7 array write without divider", r, 8'hD0);
    wr(A_STAT, 8'h10);
    rd(A_STAT, r); chk("R7 error cleared", r, 8'hC0);
    chk("R7 no start without divider", starts, 0);
    wr(A_DIV, DIVV);
    rd(A_DIV, r); chk("R7 divider readback", r, DIVV);
    rd(A_STAT, r); chk("R7 divider loaded bit", r, 8'hC1);

    // vector table: R2 R8 R9 R10
    for (int i = 0; i < 6; i++) begin
      logic [63:0] v;
      v  = VEC[i];
      s0 = starts;
      wr(v[63:48], v[47:40]);
      rd(A_STAT, r); chk("R2 buffer empty low after array write", r, 8'h41);
      wr(A_CMD, v[39:32]);
      wr(A_STAT, 8'h80);
      wait_done("R8", lat);
      chk("R8 completion latency", lat, {24'h0, v[7:0]});
      chk("R2 single start", starts, s0 + 1);
      chk("R2 start command", cap_cmd, v[39:32]);
      chk("R9 R10 start address", cap_addr, v[31:16]);
      chk("R10 start data", cap_data, v[15:8]);
      rd(A_STAT, r); chk("R2 status after completion", r, 8'hC1);
    end

    // R3 illegal code
    s0 = starts;
    wr(16'h8800, 8'h33); wr(A_CMD, 8'h21);
    rd(A_STAT, r); chk("R3 illegal code sets error", r, 8'hD1);
    wr(A_STAT, 8'h80);
    chk("R3 no start after illegal code", starts, s0);
    wr(A_STAT, 8'h10);

    // R4 abort after command, and abort right after array write
    wr(16'h8800, 8'h33); wr(A_CMD, 8'h20); wr(A_STAT, 8'h00);
    rd(A_STAT, r); chk("R4 abort after command", r, 8'hD1);
    wr(A_STAT, 8'h10);
    wr(16'h8800, 8'h33); wr(A_STAT, 8'h00);
    rd(A_STAT, r); chk("R4 abort after array write", r, 8'hD1);
    wr(A_STAT, 8'h10);
    chk("R4 no start on abort", starts, s0);

    // R5 out of order steps
    wr(A_CMD, 8'h20);
    rd(A_STAT, r); chk("R5 command without array write", r, 8'hD1);
    wr(A_STAT, 8'h10);
    wr(16'h8800, 8'h01); wr(16'h8801, 8'h02);
    rd(A_STAT, r); chk("R5 second array write", r, 8'hD1);
    wr(A_STAT, 8'h10);
    wr(16'h8800, 8'h01); wr(A_STAT, 8'h80);
    rd(A_STAT, r); chk("R5 launch without command", r, 8'hD1);
    wr(A_STAT, 8'h10);
    chk("R5 no start out of order", starts, s0);

    // R6 error blocks a complete sequence until cleared
    wr(A_CMD, 8'h20);
    wr(16'h9000, 8'h44); wr(A_CMD, 8'h20); wr(A_STAT, 8'h80);
    rd(A_STAT, r); chk("R6 sequence ignored while error", r, 8'hD1);
    chk("R6 no start while error", starts, s0);
    wr(A_STAT, 8'h10);
    rd(A_STAT, r); chk("R6 error cleared", r, 8'hC1);
    wr(16'h9000, 8'h44); wr(A_CMD, 8'h20); wr(A_STAT, 8'h80);
    wait_done("R6", lat);
    chk("R6 start after clear", starts, s0 + 1);
    chk("R6 start address after clear", cap_addr, 16'h9000);

    // R11 clear and set in the same status write
    s0 = starts;
    wr(16'hB000, 8'h55); wr(A_CMD, 8'h25); wr(A_STAT, 8'h10);
    rd(A_STAT, r); chk("R11 abort wins over clear", r, 8'hD1);
    chk("R11 no start on abort with clear", starts, s0);
    wr(A_STAT, 8'h10);
    wr(16'hB000, 8'h55); wr(A_CMD, 8'h25); wr(A_STAT, 8'h90);
    wait_done("R11", lat);
    chk("R11 launch with clear starts", starts, s0 + 1);
    chk("R11 launch with clear data", cap_data, 8'h55);
    rd(A_STAT, r); chk("R11 status after launch with clear", r, 8'hC1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule